// File: doc/BRIEF.md
# Dual-Channel Bus-Master Register Block

This block holds the control registers of a two-channel IDE bus-master DMA controller. Each channel has a window of byte registers: a command byte, a view of a mode register shared by both channels, a status byte, and a transfer-timing byte. It also merges the two drive-side interrupt requests into one level-sensitive interrupt line, with a block bit for each channel. Software reaches the registers over a simple register bus that carries an address, an access size, write data, and read and write strobes. The DMA engine watches the start and direction outputs and pulses hardware inputs that set the status bits.

The 16-byte region holds two windows. Address bit 3 picks the channel and address bits [1:0] pick the register. Addresses with bit 2 set belong to the descriptor-pointer area, which is handled outside this block. Only byte-wide accesses reach the registers. Read data is combinational, so it is valid in the same cycle as the read strobe.

Top module: `bm_regblk`

## Requirements
- R1: Address bit 3 selects channel 0 (clear) or channel 1 (set), and address bits [1:0] select command (0), mode (1), status (2) or timing (3). An access with address bit 2 set reads as zero, and a write there changes no register.
- R2: `reg_size` is 0 for a byte, 1 for 16 bits and 2 or 3 for 32 bits. A read of any size other than a byte returns all ones across its width (0x0000FFFF or 0xFFFFFFFF), and a write of such a size changes no register.
- R3: A byte write to offset 0 stores that channel's command byte, and reading offset 0 returns it. Command bit 0 drives `start[ch]` and command bit 3 drives `dir_rd[ch]`, from the clock edge that takes the write.
- R4: Offset 1 of either window reads and writes one shared mode byte. A write there sets only bit 4 (block channel 0) and bit 5 (block channel 1) from the data. Every other bit keeps its value.
- R5: Mode bit 2 (channel 0) and mode bit 3 (channel 1) are interrupt flags. Each flag takes the level of `drv_irq[ch]` at every clock edge.
- R6: `irq_out` is high exactly when some channel has its flag set and its block bit clear. It follows the registered mode byte, so it changes one cycle after the drive-side level changes or after a mode write.
- R7: A status write loads bits 5 and 6 from the data and keeps bit 0. For bits 1 and 2, a one in the data clears the bit and a zero keeps it. Bits 3, 4 and 7 become zero.
- R8: A pulse on `hw_active`, `hw_error` or `hw_done` sets status bit 0, 1 or 2 of that channel. The set wins over a write-one-to-clear of the same bit in the same cycle.
- R9: Offset 3 of each window is a separate, fully writable timing byte for that channel.
- R10: While `rst_n` is low at a clock edge, every register clears, so every read returns zero and `irq_out`, `start` and `dir_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 4 | Byte address within the 16-byte region |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| reg_wdata | input | 32 | Write data; a byte write uses bits [7:0] |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, zero when `reg_rd` is low |
| drv_irq | input | 2 | Interrupt request level from each channel's drive |
| hw_active | input | 2 | Pulse that sets status bit 0 of a channel |
| hw_error | input | 2 | Pulse that sets status bit 1 of a channel |
| hw_done | input | 2 | Pulse that sets status bit 2 of a channel |
| start | output | 2 | Command bit 0 of each channel |
| dir_rd | output | 2 | Command bit 3 of each channel |
| irq_out | output | 1 | Combined level interrupt |

## Verification
Read data does not pass through a register, so the bench checks `reg_rdata` one time step after it drives the read strobe, within the same cycle. A register write, a hardware set pulse or a change on `drv_irq` takes effect at the next rising edge. Because `irq_out` is decoded from the registered mode byte, it settles in the cycle after that edge as well. The bench keeps a behavioural model that it updates at each rising edge from the inputs it drove. It compares `start`, `dir_rd` and `irq_out` against that model at every falling edge, so each result is checked in the first cycle it is due and never earlier.

// File: rtl/bm_pkg.sv
// Shared constants for the bus-master register block.
// Assumes two channels and byte registers selected by the low two address bits.
package bm_pkg;
    localparam int NUM_CH  = 2;
    localparam int REG_W   = 8;
    localparam logic [1:0] OFF_CMD  = 2'd0;
    localparam logic [1:0] OFF_MODE = 2'd1;
    localparam logic [1:0] OFF_STAT = 2'd2;
    localparam logic [1:0] OFF_TIM  = 2'd3;
    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_HALF  = 2'd1;
    localparam logic [REG_W-1:0] STAT_WR_MASK  = 8'h60;
    localparam logic [REG_W-1:0] STAT_W1C_MASK = 8'h06;
    localparam logic [REG_W-1:0] STAT_KEEP     = 8'h01;
endpackage

// File: rtl/bm_chan_regs.sv
// Per-channel command, status and timing registers.
// Assumes write enables are already decoded and qualified to byte accesses.
module bm_chan_regs
    import bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_cmd,
    input  logic             we_stat,
    input  logic             we_tim,
    input  logic [REG_W-1:0] wdata,
    input  logic             set_act,
    input  logic             set_err,
    input  logic             set_done,
    output logic [REG_W-1:0] cmd_q,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] tim_q
);
    logic [REG_W-1:0] stat_d;

    // Next status: software write semantics first, hardware sets override.
    always_comb begin
        stat_d = stat_q;
        if (we_stat) begin
            stat_d = (wdata & STAT_WR_MASK) | (stat_q & STAT_KEEP)
                   | (stat_q & ~wdata & STAT_W1C_MASK);
        end
        if (set_act)  stat_d[0] = 1'b1;
        if (set_err)  stat_d[1] = 1'b1;
        if (set_done) stat_d[2] = 1'b1;
    end

    // Register update for command, status and timing bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            stat_q <= '0;
            tim_q  <= '0;
        end else begin
            if (we_cmd) cmd_q <= wdata;
            if (we_tim) tim_q <= wdata;
            stat_q <= stat_d;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_cmd |=> $stable(cmd_q)); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_stat && wdata[1] && !set_err) |=> !stat_q[1]); // R7
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> stat_q[1]); // R8
    AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[0] |=> stat_q[0]); // R7
    AST_TIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_tim |=> $stable(tim_q)); // R9
endmodule

// File: rtl/bm_mode_irq.sv
// Shared mode register: latched interrupt flags, per-channel block bits,
// and the combined interrupt level. Assumes we_mode is byte-qualified.
module bm_mode_irq
    import bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] drv_irq,
    input  logic              we_mode,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  mode_rd,
    output logic              irq_out
);
    logic [NUM_CH-1:0] flag_q;
    logic [NUM_CH-1:0] blk_q;

    // Flags follow drive levels; block bits load on a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            blk_q  <= '0;
        end else begin
            flag_q <= drv_irq;
            if (we_mode) blk_q <= wdata[5:4];
        end
    end

    // Mode byte view: flags at bits 3:2, block bits at 5:4.
    always_comb mode_rd = {2'b00, blk_q, flag_q, 2'b00};

    // Combined interrupt from unblocked flags.
    always_comb irq_out = |(flag_q & ~blk_q);

    AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_q == $past(drv_irq))); // R5
    AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_mode |=> $stable(blk_q)); // R4
    AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q == 2'b11) |-> !irq_out); // R6
endmodule

// File: rtl/bm_regblk.sv
// Top of the dual-channel bus-master register block: address decode,
// byte-size qualification, read multiplexer and channel instances.
// Assumes a single-cycle register bus with combinational read data.
module bm_regblk
    import bm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] drv_irq,
    input  logic [NUM_CH-1:0] hw_active,
    input  logic [NUM_CH-1:0] hw_error,
    input  logic [NUM_CH-1:0] hw_done,
    output logic [NUM_CH-1:0] start,
    output logic [NUM_CH-1:0] dir_rd,
    output logic              irq_out
);
    localparam int HALF_W = DATA_W / 2;

    logic             is_byte;
    logic             in_regs;
    logic             ch_sel;
    logic [1:0]       off;
    logic             wr_ok;
    logic [REG_W-1:0] wbyte;
    logic [REG_W-1:0] mode_rd;
    logic [REG_W-1:0] cmd_q  [NUM_CH];
    logic [REG_W-1:0] stat_q [NUM_CH];
    logic [REG_W-1:0] tim_q  [NUM_CH];
    logic [REG_W-1:0] rd_byte;

    // Decode the fields of the current access.
    always_comb begin
        is_byte = (reg_size == SZ_BYTE);
        in_regs = !reg_addr[2];
        ch_sel  = reg_addr[3];
        off     = reg_addr[1:0];
        wr_ok   = reg_wr && is_byte && in_regs;
        wbyte   = reg_wdata[REG_W-1:0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = wr_ok && (ch_sel == c[0]);
        bm_chan_regs u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_cmd   (sel && off == OFF_CMD),
            .we_stat  (sel && off == OFF_STAT),
            .we_tim   (sel && off == OFF_TIM),
            .wdata    (wbyte),
            .set_act  (hw_active[c]),
            .set_err  (hw_error[c]),
            .set_done (hw_done[c]),
            .cmd_q    (cmd_q[c]),
            .stat_q   (stat_q[c]),
            .tim_q    (tim_q[c])
        );
        assign start[c]  = cmd_q[c][0];
        assign dir_rd[c] = cmd_q[c][3];
    end

    bm_mode_irq u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv_irq (drv_irq),
        .we_mode (wr_ok && off == OFF_MODE),
        .wdata   (wbyte),
        .mode_rd (mode_rd),
        .irq_out (irq_out)
    );

    // Select the byte register addressed by the current access.
    always_comb begin
        unique case (off)
            OFF_CMD:  rd_byte = cmd_q[ch_sel];
            OFF_MODE: rd_byte = mode_rd;
            OFF_STAT: rd_byte = stat_q[ch_sel];
            default:  rd_byte = tim_q[ch_sel];
        endcase
    end

    // Form read data: all ones for wide reads, zero outside the registers.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_size == SZ_HALF)      reg_rdata = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            else if (!is_byte)            reg_rdata = '1;
            else if (in_regs)             reg_rdata = {{(DATA_W-REG_W){1'b0}}, rd_byte};
        end
    end

    AST_WIDE_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_size != SZ_BYTE) |-> (reg_rdata[HALF_W-1:0] == {HALF_W{1'b1}})); // R2
    AST_WIDE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_size != SZ_BYTE) |=> ($stable(tim_q[0]) && $stable(tim_q[1]))); // R2
    AST_HOLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[2]) |=> ($stable(cmd_q[0]) && $stable(cmd_q[1]))); // R1
endmodule

// File: tb/tb_bm_regblk.sv
module tb_bm_regblk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [1:0]  drv_irq = '0, hw_active = '0, hw_error = '0, hw_done = '0;
    logic [1:0]  start, dir_rd;
    logic        irq_out;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // Staged values applied at the next falling edge.
    logic [1:0] s_irq = '0, s_act = '0, s_err = '0, s_done = '0;

    // Behavioural model state.
    logic [7:0] m_cmd [2];
    logic [7:0] m_st  [2];
    logic [7:0] m_tim [2];
    logic [1:0] m_flag, m_blk;

    always #2.5 clk = ~clk;

    bm_regblk dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .drv_irq(drv_irq), .hw_active(hw_active), .hw_error(hw_error), .hw_done(hw_done),
        .start(start), .dir_rd(dir_rd), .irq_out(irq_out)
    );

    // Model update at each rising edge from the inputs in force.
    always @(posedge clk) begin : model
        int c;
        logic [7:0] d;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cmd[i] = 0; m_st[i] = 0; m_tim[i] = 0;
            end
            m_flag = 0; m_blk = 0;
        end else begin
            c = reg_addr[3] ? 1 : 0;
            d = reg_wdata[7:0];
            if (reg_wr && reg_size == 0 && !reg_addr[2]) begin
                case (reg_addr[1:0])
                    2'd0: m_cmd[c] = d;
                    2'd1: m_blk = d[5:4];
                    2'd2: m_st[c] = (d & 8'h60) | (m_st[c] & 8'h01) | (m_st[c] & ~d & 8'h06);
                    default: m_tim[c] = d;
                endcase
            end
            for (int i = 0; i < 2; i++) begin
                if (hw_active[i]) m_st[i][0] = 1'b1;
                if (hw_error[i])  m_st[i][1] = 1'b1;
                if (hw_done[i])   m_st[i][2] = 1'b1;
            end
            m_flag = drv_irq;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        int c = reg_addr[3] ? 1 : 0;
        if (!reg_rd) return 0;
        if (reg_size == 1) return 32'h0000FFFF;
        if (reg_size != 0) return 32'hFFFFFFFF;
        if (reg_addr[2]) return 0;
        case (reg_addr[1:0])
            2'd0: return {24'h0, m_cmd[c]};
            2'd1: return {24'h0, 2'b00, m_blk, m_flag, 2'b00};
            2'd2: return {24'h0, m_st[c]};
            default: return {24'h0, m_tim[c]};
        endcase
    endfunction

    function automatic string rd_tag();
        if (!rst_n) return "R10 read";
        if (reg_size != 0) return "R2 wide read";
        if (reg_addr[2]) return "R1 hole read";
        case (reg_addr[1:0])
            2'd0: return "R3 command read";
            2'd1: return "R4 R5 mode read";
            2'd2: return "R7 R8 status read";
            default: return "R9 timing read";
        endcase
    endfunction

    // One bus cycle: compare registered outputs, drive, then compare read data.
    task automatic op(input logic [3:0] a, input logic [1:0] sz, input logic [7:0] wd,
                      input logic w, input logic r);
        @(negedge clk);
        check(rst_n ? "R3 start" : "R10 start", {30'h0, start}, {30'h0, m_cmd[1][0], m_cmd[0][0]});
        check(rst_n ? "R3 dir" : "R10 dir", {30'h0, dir_rd}, {30'h0, m_cmd[1][3], m_cmd[0][3]});
        check(rst_n ? "R6 irq" : "R10 irq", {31'h0, irq_out}, {31'h0, |(m_flag & ~m_blk)});
        reg_addr = a; reg_size = sz; reg_wdata = {24'hA5A5A5, wd};
        reg_wr = w; reg_rd = r;
        drv_irq = s_irq; hw_active = s_act; hw_error = s_err; hw_done = s_done;
        s_act = 0; s_err = 0; s_done = 0;
        #1;
        if (r) check(rd_tag(), reg_rdata, exp_rd());
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d); op(a, 2'd0, d, 1'b1, 1'b0); endtask
    task automatic rd(input logic [3:0] a); op(a, 2'd0, 8'h00, 1'b0, 1'b1); endtask
    task automatic idle(); op(4'h0, 2'd0, 8'h00, 1'b0, 1'b0); endtask

    initial begin
        // R10: reset state of every register and output.
        rst_n = 0;
        wr(4'h3, 8'hFF); idle();
        rst_n = 1;
        for (int a = 0; a < 16; a++) rd(a[3:0]);
        // R3: command bytes and start/direction outputs.
        wr(4'h0, 8'h09); wr(4'h8, 8'h01); rd(4'h0); rd(4'h8); idle();
        // R9: independent timing bytes.
        wr(4'h3, 8'h5C); wr(4'hB, 8'hE3); rd(4'h3); rd(4'hB);
        // R2: wide writes ignored, wide reads all ones.
        op(4'h3, 2'd1, 8'h11, 1'b1, 1'b0); op(4'hB, 2'd2, 8'h22, 1'b1, 1'b0);
        rd(4'h3); rd(4'hB);
        op(4'h0, 2'd1, 8'h00, 1'b0, 1'b1); op(4'h9, 2'd2, 8'h00, 1'b0, 1'b1);
        op(4'h2, 2'd3, 8'h00, 1'b0, 1'b1);
        // R1: hole writes ignored.
        wr(4'h4, 8'hFF); wr(4'hC, 8'hFF); rd(4'h4); rd(4'h0); rd(4'h8);
        // R5 R6: flags follow drive levels, irq one cycle later.
        s_irq = 2'b01; idle(); idle(); rd(4'h1);
        s_irq = 2'b10; idle(); idle(); rd(4'h9);
        // R4: mode write via channel 1 window, only bits 5:4 change.
        wr(4'h9, 8'hFF); rd(4'h1); idle();
        wr(4'h1, 8'h10); rd(4'h9); idle();
        s_irq = 2'b01; idle(); idle();
        wr(4'h1, 8'h00); idle(); rd(4'h1);
        s_irq = 2'b00; idle(); idle();
        // R8: hardware sets; R7: status write semantics.
        s_act = 2'b01; s_err = 2'b11; s_done = 2'b10; idle(); rd(4'h2); rd(4'hA);
        wr(4'h2, 8'hFF); rd(4'h2);
        wr(4'hA, 8'h02); rd(4'hA);
        wr(4'hA, 8'h00); rd(4'hA);
        s_err = 2'b01; wr(4'h2, 8'h06); rd(4'h2);
        wr(4'h2, 8'h66); rd(4'h2);
        // Mixed random traffic against the model.
        for (int i = 0; i < 600; i++) begin
            logic [1:0] sz;
            sz = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            s_irq = 2'($urandom); s_act = 2'($urandom_range(0, 7) == 0 ? $urandom : 0);
            s_err = 2'($urandom); s_done = 2'($urandom);
            op(4'($urandom), sz, 8'($urandom), 1'($urandom), 1'($urandom));
        end
        // R10: reset mid-run clears everything.
        rst_n = 0; idle(); rd(4'h2); rd(4'h9);
        rst_n = 1; s_irq = 0; idle(); rd(4'h0); rd(4'h1); rd(4'hA); rd(4'hB); idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule